// File: doc/BRIEF.md
# Clock Prescaler Enable Tree

This block turns one fast reference clock into a family of single-cycle clock enables for the bus, timer, converter, serial-bus and calendar domains of a chip. Nothing in it produces a divided clock. Every output is a one-cycle pulse in the reference domain, and downstream logic uses it to qualify its flops. Software-facing configuration arrives as plain select inputs. The tree applies each new ratio only when the affected divider has finished its current period.

The enables form a hierarchy. The high-speed bus enable divides the reference. Each of the two peripheral bus enables divides the high-speed bus enable. The converter enable divides the second peripheral bus enable. The timer enable of each peripheral domain runs at the peripheral rate when that prescaler is 1, and at twice that rate otherwise. A serial-bus enable runs from the reference either undivided or at a 2-of-3 rate. A calendar enable is a fixed division of the reference. All enables are registered, so every output sits exactly one cycle behind the counter state that produced it. A child pulse therefore always coincides with a pulse of its parent.

Top module: `cen_tree`

## Requirements
- R1: `hclk_en` pulses once every 2^n reference cycles, where n is `ahb_sel`. Any value above 9 is treated as 9, which gives 512.
- R2: Each of `pclk1_en` and `pclk2_en` pulses on every 2^m-th pulse of `hclk_en`, where m is its select (`apb1_sel`, `apb2_sel`). Values above 4 are treated as 4.
- R3: When a peripheral divide is 1, each timer enable equals its peripheral enable. Otherwise the timer enable pulses on the `hclk_en` pulse that starts each peripheral period and on the pulse halfway through that period.
- R4: `adc_en` pulses on every 2(k+1)-th pulse of `pclk2_en`, where k is `adc_sel` (0..3). This gives divides of 2, 4, 6 and 8.
- R5: With `usb_frac`=0, `usb_en` is high every cycle. With `usb_frac`=1, it follows the repeating pattern 1,1,0, which is two pulses per three reference cycles.
- R6: `rtc_en` pulses once every 128 reference cycles.
- R7: A select change never shortens or stretches a running period. The divider finishes its current period at the old ratio, and the next period uses the new one. The serial-bus mode switches only at the end of a three-cycle group.
- R8: While `rst` is high, all enables are low. On the first clock edge after `rst` falls, all enables pulse together.
- R9: No child enable is ever high in a cycle where its parent is low. The peripheral and timer enables sit inside `hclk_en`, and `adc_en` sits inside `pclk2_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ahb_sel | input | 4 | High-speed bus divide exponent (divide = 2^n, saturating at 9) |
| apb1_sel | input | 3 | First peripheral bus divide exponent (saturating at 4) |
| apb2_sel | input | 3 | Second peripheral bus divide exponent (saturating at 4) |
| adc_sel | input | 2 | Converter divide code k, divide = 2(k+1) |
| usb_frac | input | 1 | 0: serial-bus enable every cycle, 1: divide by 1.5 |
| hclk_en | output | 1 | High-speed bus enable |
| pclk1_en | output | 1 | First peripheral bus enable |
| pclk2_en | output | 1 | Second peripheral bus enable |
| tim1_en | output | 1 | Timer enable of the first peripheral domain |
| tim2_en | output | 1 | Timer enable of the second peripheral domain |
| adc_en | output | 1 | Converter enable |
| usb_en | output | 1 | Serial-bus enable |
| rtc_en | output | 1 | Calendar enable |

## Verification
The bench builds `cen_tree` with its default parameters. With those, the widest exponents are 9 for the high-speed bus and 4 for the peripheral buses, and the calendar divide is 128, so both the saturating select values and the deepest ratios are reachable. Random select sets with short to long dwell times land ratio changes at every phase of a running period. Small high-speed divides make the converter enable tick often enough to compare its pattern many times. A directed run uses out-of-range selects to exercise saturation, and another directed case measures the exact gaps around a mid-period ratio change.

// File: rtl/cen_pkg.sv
package cen_pkg;

  // Registered bundle of every enable produced by the tree
  typedef struct packed {
    logic hclk;
    logic pclk1;
    logic pclk2;
    logic tim1;
    logic tim2;
    logic adc;
    logic usb;
    logic rtc;
  } cen_ticks_t;

  typedef enum logic { USB_FULL = 1'b0, USB_TWO_THIRDS = 1'b1 } usb_mode_e;

  localparam int unsigned USB_GROUP = 3;

endpackage

// File: rtl/cen_stage.sv
// One prescaler stage: counts parent ticks, fires on count zero, and
// reloads its terminal count only when the period wraps.
module cen_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         par_fire,
  input  logic [W-1:0] tc_req,
  output logic         fire,
  output logic         half_fire
);

  logic [W-1:0] cnt;
  logic [W-1:0] tc_cur;
  logic [W:0]   mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tc_cur <= tc_req;
    end else if (par_fire) begin
      if (cnt == tc_cur) begin
        cnt    <= '0;
        tc_cur <= tc_req;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign mid       = ({1'b0, tc_cur} + (W+1)'(1)) >> 1;
  assign fire      = par_fire && (cnt == '0);
  assign half_fire = par_fire && (tc_cur != '0) && ({1'b0, cnt} == mid);

endmodule

// File: rtl/cen_frac15.sv
// Divide-by-1.5 enable: groups of three cycles, the last one masked.
module cen_frac15 (
  input  logic clk,
  input  logic rst,
  input  logic mode_req,
  output logic fire
);
  import cen_pkg::*;

  logic [1:0] phase;
  usb_mode_e  mode_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      mode_cur <= usb_mode_e'(mode_req);
    end else if (phase == 2'(USB_GROUP - 1)) begin
      phase    <= '0;
      mode_cur <= usb_mode_e'(mode_req);
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign fire = (mode_cur == USB_FULL) || (phase != 2'(USB_GROUP - 1));

endmodule

// File: rtl/cen_tree.sv
module cen_tree #(
  parameter int AHB_SEL_W   = 4,
  parameter int AHB_MAX_LOG = 9,
  parameter int APB_SEL_W   = 3,
  parameter int APB_MAX_LOG = 4,
  parameter int ADC_SEL_W   = 2,
  parameter int RTC_DIV     = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AHB_SEL_W-1:0] ahb_sel,
  input  logic [APB_SEL_W-1:0] apb1_sel,
  input  logic [APB_SEL_W-1:0] apb2_sel,
  input  logic [ADC_SEL_W-1:0] adc_sel,
  input  logic                 usb_frac,
  output logic                 hclk_en,
  output logic                 pclk1_en,
  output logic                 pclk2_en,
  output logic                 tim1_en,
  output logic                 tim2_en,
  output logic                 adc_en,
  output logic                 usb_en,
  output logic                 rtc_en
);
  import cen_pkg::*;

  localparam int AHB_CNT_W = AHB_MAX_LOG;
  localparam int APB_CNT_W = APB_MAX_LOG;
  localparam int ADC_CNT_W = ADC_SEL_W + 1;
  localparam int RTC_CNT_W = $clog2(RTC_DIV);
  localparam int NUM_APB   = 2;

  // Divide exponents saturate at the widest supported ratio
  logic [AHB_SEL_W-1:0] ahb_eff;
  logic [AHB_CNT_W-1:0] ahb_tc;
  logic [APB_SEL_W-1:0] apb_sel_a [NUM_APB];
  logic [APB_CNT_W-1:0] apb_tc    [NUM_APB];
  logic [ADC_CNT_W-1:0] adc_tc;

  always_comb begin
    ahb_eff = (ahb_sel > AHB_SEL_W'(AHB_MAX_LOG)) ? AHB_SEL_W'(AHB_MAX_LOG) : ahb_sel;
    ahb_tc  = ~({AHB_CNT_W{1'b1}} << ahb_eff);
    adc_tc  = {adc_sel, 1'b1};
  end

  assign apb_sel_a[0] = apb1_sel;
  assign apb_sel_a[1] = apb2_sel;

  logic h_fire;
  logic h_half_unused;
  logic p_fire [NUM_APB];
  logic p_half [NUM_APB];
  logic t_fire [NUM_APB];
  logic a_fire, a_half_unused;
  logic r_fire, r_half_unused;
  logic u_fire;

  cen_stage #(.W(AHB_CNT_W)) i_ahb (
    .clk(clk), .rst(rst), .par_fire(1'b1), .tc_req(ahb_tc),
    .fire(h_fire), .half_fire(h_half_unused)
  );

  for (genvar g = 0; g < NUM_APB; g++) begin : g_apb
    logic [APB_SEL_W-1:0] eff;
    always_comb begin
      eff       = (apb_sel_a[g] > APB_SEL_W'(APB_MAX_LOG)) ? APB_SEL_W'(APB_MAX_LOG) : apb_sel_a[g];
      apb_tc[g] = ~({APB_CNT_W{1'b1}} << eff);
    end

    cen_stage #(.W(APB_CNT_W)) i_apb (
      .clk(clk), .rst(rst), .par_fire(h_fire), .tc_req(apb_tc[g]),
      .fire(p_fire[g]), .half_fire(p_half[g])
    );

    // Timer rate doubles whenever the bus divide is above one
    assign t_fire[g] = p_fire[g] || p_half[g];
  end

  cen_stage #(.W(ADC_CNT_W)) i_adc (
    .clk(clk), .rst(rst), .par_fire(p_fire[1]), .tc_req(adc_tc),
    .fire(a_fire), .half_fire(a_half_unused)
  );

  cen_stage #(.W(RTC_CNT_W)) i_rtc (
    .clk(clk), .rst(rst), .par_fire(1'b1), .tc_req(RTC_CNT_W'(RTC_DIV - 1)),
    .fire(r_fire), .half_fire(r_half_unused)
  );

  cen_frac15 i_usb (
    .clk(clk), .rst(rst), .mode_req(usb_frac), .fire(u_fire)
  );

  // All enables registered together so parent and child stay aligned
  cen_ticks_t ticks_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks_q <= '0;
    end else begin
      ticks_q.hclk  <= h_fire;
      ticks_q.pclk1 <= p_fire[0];
      ticks_q.pclk2 <= p_fire[1];
      ticks_q.tim1  <= t_fire[0];
      ticks_q.tim2  <= t_fire[1];
      ticks_q.adc   <= a_fire;
      ticks_q.usb   <= u_fire;
      ticks_q.rtc   <= r_fire;
    end
  end

  assign hclk_en  = ticks_q.hclk;
  assign pclk1_en = ticks_q.pclk1;
  assign pclk2_en = ticks_q.pclk2;
  assign tim1_en  = ticks_q.tim1;
  assign tim2_en  = ticks_q.tim2;
  assign adc_en   = ticks_q.adc;
  assign usb_en   = ticks_q.usb;
  assign rtc_en   = ticks_q.rtc;

endmodule

// File: rtl/cen_tree_chk.sv
module cen_tree_chk (
  input logic clk,
  input logic rst,
  input logic hclk_en,
  input logic pclk1_en,
  input logic pclk2_en,
  input logic tim1_en,
  input logic tim2_en,
  input logic adc_en,
  input logic usb_en,
  input logic rtc_en
);

  p_pclk_in_hclk_r9: assert property (@(posedge clk) disable iff (rst)
    (pclk1_en || pclk2_en || tim1_en || tim2_en) |-> hclk_en);

  p_tim_covers_pclk_r3: assert property (@(posedge clk) disable iff (rst)
    (pclk1_en |-> tim1_en) and (pclk2_en |-> tim2_en));

  p_adc_in_pclk2_r4: assert property (@(posedge clk) disable iff (rst)
    adc_en |-> pclk2_en);

  p_usb_no_double_gap_r5: assert property (@(posedge clk) disable iff (rst)
    !usb_en |=> usb_en);

  p_rtc_single_r6: assert property (@(posedge clk) disable iff (rst)
    rtc_en |=> !rtc_en);

  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> !(hclk_en || pclk1_en || pclk2_en || tim1_en || tim2_en || adc_en || usb_en || rtc_en));

endmodule

bind cen_tree cen_tree_chk i_chk (
  .clk(clk), .rst(rst), .hclk_en(hclk_en), .pclk1_en(pclk1_en),
  .pclk2_en(pclk2_en), .tim1_en(tim1_en), .tim2_en(tim2_en),
  .adc_en(adc_en), .usb_en(usb_en), .rtc_en(rtc_en)
);

// File: tb/test_cen_tree.sv
module test_cen_tree;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ahb_sel = 4'd0;
  logic [2:0] apb1_sel = 3'd0;
  logic [2:0] apb2_sel = 3'd0;
  logic [1:0] adc_sel = 2'd0;
  logic       usb_frac = 1'b0;
  logic hclk_en, pclk1_en, pclk2_en, tim1_en, tim2_en, adc_en, usb_en, rtc_en;

  always #5 clk = ~clk;

  cen_tree i_cen_tree (
    .clk(clk), .rst(rst), .ahb_sel(ahb_sel), .apb1_sel(apb1_sel),
    .apb2_sel(apb2_sel), .adc_sel(adc_sel), .usb_frac(usb_frac),
    .hclk_en(hclk_en), .pclk1_en(pclk1_en), .pclk2_en(pclk2_en),
    .tim1_en(tim1_en), .tim2_en(tim2_en), .adc_en(adc_en),
    .usb_en(usb_en), .rtc_en(rtc_en)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Ratios decoded straight from the requirement text
  function automatic int ahb_len(input logic [3:0] s);
    return 1 << ((s > 9) ? 9 : s);
  endfunction
  function automatic int apb_len(input logic [2:0] s);
    return 1 << ((s > 4) ? 4 : s);
  endfunction
  function automatic int adc_len(input logic [1:0] s);
    return 2 * (int'(s) + 1);
  endfunction

  // Reference model: position within each period, in parent ticks
  int h_pos, h_len, a_pos, a_len, r_pos, u_ph;
  int p_pos [2];
  int p_len [2];
  bit u_mode;
  logic e_h, e_p1, e_p2, e_t1, e_t2, e_a, e_u, e_r;

  always @(posedge clk) begin
    bit hf, af, uf, rf;
    bit pf [2];
    bit tf [2];
    if (rst) begin
      h_pos = 0; h_len = ahb_len(ahb_sel);
      p_pos[0] = 0; p_len[0] = apb_len(apb1_sel);
      p_pos[1] = 0; p_len[1] = apb_len(apb2_sel);
      a_pos = 0; a_len = adc_len(adc_sel);
      r_pos = 0; u_ph = 0; u_mode = usb_frac;
      {e_h, e_p1, e_p2, e_t1, e_t2, e_a, e_u, e_r} = '0;
    end else begin
      hf = (h_pos == 0);
      if (h_pos == h_len - 1) begin h_pos = 0; h_len = ahb_len(ahb_sel); end
      else h_pos++;
      for (int g = 0; g < 2; g++) begin
        pf[g] = hf && (p_pos[g] == 0);
        tf[g] = pf[g] || (hf && p_len[g] > 1 && p_pos[g] == p_len[g] / 2);
        if (hf) begin
          if (p_pos[g] == p_len[g] - 1) begin
            p_pos[g] = 0;
            p_len[g] = apb_len(g == 0 ? apb1_sel : apb2_sel);
          end else p_pos[g]++;
        end
      end
      af = pf[1] && (a_pos == 0);
      if (pf[1]) begin
        if (a_pos == a_len - 1) begin a_pos = 0; a_len = adc_len(adc_sel); end
        else a_pos++;
      end
      uf = !u_mode || (u_ph != 2);
      if (u_ph == 2) begin u_ph = 0; u_mode = usb_frac; end
      else u_ph++;
      rf = (r_pos == 0);
      r_pos = (r_pos + 1) % 128;
      {e_h, e_p1, e_p2, e_t1, e_t2, e_a, e_u, e_r} =
        {hf, pf[0], pf[1], tf[0], tf[1], af, uf, rf};
    end
  end

  task automatic check_cycle();
    chk("R1 hclk", hclk_en, e_h);
    chk("R2 pclk1", pclk1_en, e_p1);
    chk("R2 pclk2", pclk2_en, e_p2);
    chk("R3 tim1", tim1_en, e_t1);
    chk("R3 tim2", tim2_en, e_t2);
    chk("R4 adc", adc_en, e_a);
    chk("R5 usb", usb_en, e_u);
    chk("R6 rtc", rtc_en, e_r);
    if ((pclk1_en || pclk2_en || tim1_en || tim2_en) && !hclk_en) chk("R9 nesting", 1'b1, 1'b0);
    if (adc_en && !pclk2_en) chk("R9 adc nesting", 1'b1, 1'b0);
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_cycle();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int gap;
    void'($urandom(32'd2024));
    // R8: quiet during reset
    ahb_sel = 4'd1; apb1_sel = 3'd1; apb2_sel = 3'd0; adc_sel = 2'd0; usb_frac = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 reset quiet", |{hclk_en, pclk1_en, pclk2_en, tim1_en, tim2_en, adc_en, usb_en, rtc_en}, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 first edge all pulse", &{hclk_en, pclk1_en, pclk2_en, tim1_en, tim2_en, adc_en, usb_en, rtc_en}, 1'b1);
    check_cycle();
    run(600);

    // R7: mid-period change of the high-speed divide from /8 to /2
    ahb_sel = 4'd3;
    run(20);
    do begin @(negedge clk); check_cycle(); end while (!hclk_en);
    run(2);
    ahb_sel = 4'd1;
    gap = 2;
    do begin @(negedge clk); check_cycle(); gap++; end while (!hclk_en);
    chk_int("R7 old period completes", gap, 8);
    gap = 0;
    do begin @(negedge clk); check_cycle(); gap++; end while (!hclk_en);
    chk_int("R7 new period applied", gap, 2);

    // R1 R2: out-of-range selects saturate
    ahb_sel = 4'd14; apb1_sel = 3'd7; apb2_sel = 3'd5; adc_sel = 2'd3;
    run(20000);

    // Random select sets with random dwell
    for (int s = 0; s < 30; s++) begin
      ahb_sel  = 4'($urandom_range(0, 4));
      if ($urandom_range(0, 5) == 0) ahb_sel = 4'($urandom_range(5, 15));
      apb1_sel = 3'($urandom_range(0, 7));
      apb2_sel = 3'($urandom_range(0, 7));
      adc_sel  = 2'($urandom_range(0, 3));
      usb_frac = 1'($urandom_range(0, 1));
      run($urandom_range(150, 4000));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule